// File: doc/BRIEF.md
# Three-Phase Grid Phase Tracker (Synchronous Frame)

This block estimates the phase angle and frequency of a three-phase utility voltage from one set of fixed-point phase samples per control period. On each sample strobe it converts the three phase voltages to a two-axis stationary vector. It rotates that vector into a frame that turns at the estimated angle, smooths the two rotated components in an in-loop stage, and feeds the direct-axis component to a proportional-integral loop filter. The filter output is a phase increment per sample. A wrapping phase accumulator integrates it into the angle, and sine and cosine of that angle come from a quarter-wave table.

The loop counts as locked when the voltage vector sits on the quadrature axis. The quadrature output then reads the positive-sequence amplitude and the direct output reads zero. The in-loop smoothing stage sits between the rotation and the loop filter, and a sequence-separation filter can be put in its place.

Voltages are per-unit with 1.0 = 16384 (signed 16-bit). Angle and frequency are 32-bit unsigned phase words: a full turn is 2^32, and frequency is the increment added per sample at a 6 kHz sample rate. Loop gains follow a damping of 0.707 and a natural frequency of 62.8 rad/s, which gives 89 proportional and 3948 integral in per-unit.

Top module: `grid_pll_srf`

## Requirements
- R1: While reset is low and on the first cycle after it rises, theta_o is 0, freq_o is 42949673 (60 Hz), and vd_o and vq_o are 0.
- R2: A clock edge without smp_en leaves all four outputs unchanged, whatever the phase inputs carry.
- R3: A common value added to va, vb and vc (zero sequence) has no effect on any output.
- R4: The stationary vector is α = floor((2·va − vb − vc)·21845 / 2^16) and β = floor((vb − vc)·37837 / 2^16). The top 10 bits of theta_o select one of 1024 angle steps, and sin/cos are the rounded values of 16384·sin and 16384·cos of that step. The rotated direct component is floor((α·cos + β·sin) / 2^14).
- R5: The rotated quadrature component is floor((β·cos − α·sin) / 2^14). Each rotated component passes through a state y ← y + floor((x − y)/4) on every strobe, and vd_o and vq_o show these states.
- R6: The loop error is e = −(new direct state). The integral I (reset to 42949673·256) becomes I + 1171·e, clamped to [28633115·256, 50107952·256] (40 Hz to 70 Hz). freq_o becomes floor((I + 158430·e)/256).
- R7: On each strobe theta_o becomes (old theta_o + new freq_o) mod 2^32.
- R8: With a balanced 60 Hz input of 0.8 pu, after settling the mean of vd_o over one period is within 100 LSB of 0, and vq_o stays within 2.5 % of 13107.
- R9: After a step of the input from 60 Hz to 50 Hz, vq_o stays above 0.5 pu throughout. After settling, the mean of freq_o is within 71583 (0.1 Hz) of 35791394 (50 Hz).
- R10: Under an input the loop cannot follow (a stationary vector), freq_o never falls below the 40 Hz clamp minus the largest proportional excursion, i.e. never below 28633115 − 8666000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample strobe, one control period per pulse |
| va | input | 16 | Phase A voltage, signed per-unit |
| vb | input | 16 | Phase B voltage, signed per-unit |
| vc | input | 16 | Phase C voltage, signed per-unit |
| theta_o | output | 32 | Estimated angle, full turn = 2^32 |
| freq_o | output | 32 | Estimated frequency as phase increment per sample |
| vd_o | output | 16 | Smoothed direct-axis voltage |
| vq_o | output | 16 | Smoothed quadrature-axis voltage |

## Verification
The assertions assume that reset is asserted from time zero and that each phase input stays within ±1.0 pu. Within that range the stationary and rotated sums fit their 16-bit results, so the integral window and the hold and accumulation relations are the only invariants checked. The stimulus keeps the sum of positive, negative and zero sequence amplitudes below 1.0 pu. The random values driven between strobes are drawn from the same ±1.0 pu range, so every input the design sees stays inside these assumptions.

// File: rtl/grid_pll_srf.sv
module grid_pll_srf #(
  parameter int     VW      = 16,
  parameter int     PW      = 32,
  parameter int     TB      = 8,
  parameter int     FSH     = 2,
  parameter int     AW      = 40,
  parameter int     GSH     = 8,
  parameter longint NOM_INC = 42949673,
  parameter longint MIN_INC = 28633115,
  parameter longint MAX_INC = 50107952,
  parameter int     KP      = 158430,
  parameter int     KI      = 1171,
  parameter int     K_THIRD = 21845,
  parameter int     K_RT3   = 37837
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic signed [VW-1:0] va,
  input  logic signed [VW-1:0] vb,
  input  logic signed [VW-1:0] vc,
  output logic        [PW-1:0] theta_o,
  output logic        [PW-1:0] freq_o,
  output logic signed [VW-1:0] vd_o,
  output logic signed [VW-1:0] vq_o
);
  localparam int QN  = 1 << TB;
  localparam int ONE = 1 << (VW - 2);
  localparam int CW  = VW + 3;
  localparam int MW  = CW + 18;
  localparam int PKW = 2 * VW + 1;
  localparam logic signed [AW-1:0] INTEG_NOM = AW'(NOM_INC) <<< GSH;
  localparam logic signed [AW-1:0] INTEG_LO  = AW'(MIN_INC) <<< GSH;
  localparam logic signed [AW-1:0] INTEG_HI  = AW'(MAX_INC) <<< GSH;
  localparam logic signed [AW-1:0] KP_S      = AW'(KP);
  localparam logic signed [AW-1:0] KI_S      = AW'(KI);

  // quarter-wave sine point k of QN, Taylor series in Q30, rounded to Q(VW-2)
  function automatic longint qsin(input int k);
    longint x, t, s;
    x = (longint'(k) * 64'sd1686629713) / longint'(QN);
    t = x;
    s = x;
    for (int i = 1; i <= 6; i++) begin
      t = -((((t * x) >>> 30) * x) >>> 30) / longint'((2 * i) * (2 * i + 1));
      s = s + t;
    end
    return (s * longint'(ONE) + (64'sd1 <<< 29)) >>> 30;
  endfunction

  function automatic logic signed [VW-1:0] fold(input logic [1:0] q,
                                                input logic signed [VW-1:0] up,
                                                input logic signed [VW-1:0] dn);
    logic signed [VW-1:0] m;
    m = q[0] ? dn : up;
    return q[1] ? -m : m;
  endfunction

  logic signed [VW-1:0] sin_tab [QN+1];
  for (genvar gi = 0; gi <= QN; gi++) begin : g_tab
    assign sin_tab[gi] = VW'(qsin(gi));
  end

  logic        [PW-1:0] theta_q, freq_q;
  logic signed [VW-1:0] vdf_q, vqf_q, vdf_n, vqf_n;
  logic signed [AW-1:0] integ_q, integ_s, integ_n;

  logic signed [CW-1:0] sum_a, sum_b;
  logic signed [VW-1:0] v_al, v_be;
  assign sum_a = (CW'(va) <<< 1) - CW'(vb) - CW'(vc);
  assign sum_b = CW'(vb) - CW'(vc);
  assign v_al  = VW'((MW'(sum_a) * MW'(K_THIRD)) >>> 16);
  assign v_be  = VW'((MW'(sum_b) * MW'(K_RT3)) >>> 16);

  logic        [TB+1:0] ph;
  logic        [1:0]    qc;
  logic signed [VW-1:0] t_up, t_dn, sin_v, cos_v;
  assign ph    = theta_q[PW-1 -: TB+2];
  assign qc    = ph[TB+1:TB] + 2'd1;
  assign t_up  = sin_tab[{1'b0, ph[TB-1:0]}];
  assign t_dn  = sin_tab[(TB+1)'(QN) - {1'b0, ph[TB-1:0]}];
  assign sin_v = fold(ph[TB+1:TB], t_up, t_dn);
  assign cos_v = fold(qc, t_up, t_dn);

  logic signed [VW-1:0] vd_raw, vq_raw;
  assign vd_raw = VW'((PKW'(v_al) * PKW'(cos_v) + PKW'(v_be) * PKW'(sin_v)) >>> (VW - 2));
  assign vq_raw = VW'((PKW'(v_be) * PKW'(cos_v) - PKW'(v_al) * PKW'(sin_v)) >>> (VW - 2));

  if (FSH == 0) begin : g_pass
    assign vdf_n = vd_raw;
    assign vqf_n = vq_raw;
  end else begin : g_lpf
    assign vdf_n = vdf_q + VW'(((VW+1)'(vd_raw) - (VW+1)'(vdf_q)) >>> FSH);
    assign vqf_n = vqf_q + VW'(((VW+1)'(vq_raw) - (VW+1)'(vqf_q)) >>> FSH);
  end

  logic signed [VW:0]   err;
  logic        [PW-1:0] inc_n;
  assign err     = -((VW+1)'(vdf_n));
  assign integ_s = integ_q + AW'(err) * KI_S;
  assign integ_n = (integ_s > INTEG_HI) ? INTEG_HI :
                   (integ_s < INTEG_LO) ? INTEG_LO : integ_s;
  assign inc_n   = PW'((integ_n + AW'(err) * KP_S) >>> GSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      theta_q <= '0;
      freq_q  <= PW'(NOM_INC);
      vdf_q   <= '0;
      vqf_q   <= '0;
      integ_q <= INTEG_NOM;
    end else if (smp_en) begin
      theta_q <= theta_q + inc_n;
      freq_q  <= inc_n;
      vdf_q   <= vdf_n;
      vqf_q   <= vqf_n;
      integ_q <= integ_n;
    end
  end

  assign theta_o = theta_q;
  assign freq_o  = freq_q;
  assign vd_o    = vdf_q;
  assign vq_o    = vqf_q;
endmodule

// File: rtl/grid_pll_srf_chk.sv
module grid_pll_srf_chk #(
  parameter int     PW      = 32,
  parameter int     VW      = 16,
  parameter int     AW      = 40,
  parameter int     GSH     = 8,
  parameter longint NOM_INC = 42949673,
  parameter longint MIN_INC = 28633115,
  parameter longint MAX_INC = 50107952
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_en,
  input logic        [PW-1:0] theta_o,
  input logic        [PW-1:0] freq_o,
  input logic signed [VW-1:0] vd_o,
  input logic signed [VW-1:0] vq_o,
  input logic signed [AW-1:0] integ_q
);
  localparam logic signed [AW-1:0] LO = AW'(MIN_INC) <<< GSH;
  localparam logic signed [AW-1:0] HI = AW'(MAX_INC) <<< GSH;

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (theta_o == '0 && freq_o == PW'(NOM_INC) && vd_o == '0 && vq_o == '0));

  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(theta_o) && $stable(freq_o) && $stable(vd_o) && $stable(vq_o)));

  // R6
  integ_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q >= LO && integ_q <= HI));

  // R7
  phase_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> (theta_o == PW'($past(theta_o) + freq_o)));
endmodule

bind grid_pll_srf grid_pll_srf_chk #(
  .PW(PW), .VW(VW), .AW(AW), .GSH(GSH),
  .NOM_INC(NOM_INC), .MIN_INC(MIN_INC), .MAX_INC(MAX_INC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
  .theta_o(theta_o), .freq_o(freq_o), .vd_o(vd_o), .vq_o(vq_o),
  .integ_q(integ_q)
);

// File: tb/sim_grid_pll_srf.sv
module sim_grid_pll_srf;
  localparam real    TWO_PI = 6.283185307179586;
  localparam real    FS     = 6000.0;
  localparam longint NOM    = 42949673;
  localparam longint FMIN   = 28633115;
  localparam longint FMAX   = 50107952;
  localparam longint F50    = 35791394;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic signed [15:0] va = '0, vb = '0, vc = '0;
  logic [31:0] theta_o, freq_o;
  logic signed [15:0] vd_o, vq_o;

  always #2 clk = ~clk;

  grid_pll_srf u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
    .va(va), .vb(vb), .vc(vc),
    .theta_o(theta_o), .freq_o(freq_o), .vd_o(vd_o), .vq_o(vq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  longint m_theta, m_integ, m_freq, m_vdf, m_vqf;
  longint tab [1024];
  real ph = 0.0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_theta = 0;
    m_integ = NOM * 256;
    m_freq  = NOM;
    m_vdf   = 0;
    m_vqf   = 0;
  endtask

  task automatic model_step(input longint a, input longint b, input longint c);
    longint al, be, s, co, vd, vq, e, ig;
    int p;
    al = ((2 * a - b - c) * 21845) >>> 16;
    be = ((b - c) * 37837) >>> 16;
    p  = int'(m_theta >> 22);
    s  = tab[p];
    co = tab[(p + 256) % 1024];
    vd = (al * co + be * s) >>> 14;
    vq = (be * co - al * s) >>> 14;
    m_vdf = m_vdf + ((vd - m_vdf) >>> 2);
    m_vqf = m_vqf + ((vq - m_vqf) >>> 2);
    e  = -m_vdf;
    ig = m_integ + 1171 * e;
    if (ig > FMAX * 256) ig = FMAX * 256;
    if (ig < FMIN * 256) ig = FMIN * 256;
    m_integ = ig;
    m_freq  = (ig + 158430 * e) >>> 8;
    m_theta = (m_theta + m_freq) & 64'hFFFF_FFFF;
  endtask

  function automatic logic signed [15:0] rnd_v();
    return 16'(int'($urandom_range(32768)) - 16384);
  endfunction

  task automatic sample(input real vp, input real vn, input real vz, input real f, input string tag);
    longint a, b, c, z;
    logic [31:0] h_th, h_fr;
    logic signed [15:0] h_vd, h_vq;
    ph = ph + TWO_PI * f / FS;
    a = longint'($rtoi(16384.0 * (vp * $cos(ph) + vn * $cos(ph))));
    b = longint'($rtoi(16384.0 * (vp * $cos(ph - TWO_PI / 3.0) + vn * $cos(ph + TWO_PI / 3.0))));
    c = longint'($rtoi(16384.0 * (vp * $cos(ph + TWO_PI / 3.0) + vn * $cos(ph - TWO_PI / 3.0))));
    z = longint'($rtoi(16384.0 * vz * $cos(ph)));
    @(negedge clk);
    va = 16'(a + z);
    vb = 16'(b + z);
    vc = 16'(c + z);
    smp_en = 1'b1;
    @(posedge clk);
    model_step(a, b, c);
    @(negedge clk);
    smp_en = 1'b0;
    chk(longint'(theta_o) == m_theta, {tag, " R7 angle"}, longint'(theta_o), m_theta);
    chk(longint'(freq_o) == m_freq, {tag, " R6 freq"}, longint'(freq_o), m_freq);
    chk(longint'(vd_o) == m_vdf, {tag, " R4 vd"}, longint'(vd_o), m_vdf);
    chk(longint'(vq_o) == m_vqf, {tag, " R5 vq"}, longint'(vq_o), m_vqf);
    h_th = theta_o; h_fr = freq_o; h_vd = vd_o; h_vq = vq_o;
    va = rnd_v(); vb = rnd_v(); vc = rnd_v();
    @(negedge clk);
    chk(theta_o == h_th && freq_o == h_fr && vd_o == h_vd && vq_o == h_vq,
        "R2 hold without strobe", longint'(theta_o), longint'(h_th));
  endtask

  task automatic check_reset_state();
    chk(theta_o == 32'd0, "R1 theta", longint'(theta_o), 0);
    chk(longint'(freq_o) == NOM, "R1 freq", longint'(freq_o), NOM);
    chk(vd_o == 16'sd0, "R1 vd", longint'(vd_o), 0);
    chk(vq_o == 16'sd0, "R1 vq", longint'(vq_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint acc;
    for (int k = 0; k < 1024; k++) begin
      real sv;
      longint mag;
      sv  = $sin(TWO_PI * real'(k) / 1024.0);
      mag = longint'($rtoi((sv < 0.0 ? -sv : sv) * 16384.0 + 0.5));
      tab[k] = (sv < 0.0) ? -mag : mag;
    end
    model_reset();
    repeat (5) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    // R8: balanced 60 Hz lock
    for (int i = 0; i < 1500; i++) sample(0.8, 0.0, 0.0, 60.0, "lock");
    acc = 0;
    for (int i = 0; i < 100; i++) begin
      sample(0.8, 0.0, 0.0, 60.0, "lock");
      acc = acc + longint'(vd_o);
      chk(vq_o >= 16'sd12780 && vq_o <= 16'sd13435, "R8 vq amplitude", longint'(vq_o), 13107);
    end
    chk(acc / 100 <= 100 && acc / 100 >= -100, "R8 mean vd", acc / 100, 0);

    // R3: unbalance plus zero sequence; the model sees no zero sequence
    for (int i = 0; i < 600; i++) sample(0.7, 0.1, 0.15, 60.0, "R3 zero-seq");

    // R9: frequency step to 50 Hz
    for (int i = 0; i < 1500; i++) begin
      sample(0.8, 0.0, 0.0, 50.0, "step");
      chk(vq_o > 16'sd8192, "R9 lock kept", longint'(vq_o), 8192);
    end
    acc = 0;
    for (int i = 0; i < 120; i++) begin
      sample(0.8, 0.0, 0.0, 50.0, "step");
      acc = acc + longint'(freq_o);
    end
    chk(acc / 120 <= F50 + 71583 && acc / 120 >= F50 - 71583, "R9 mean freq", acc / 120, F50);

    // R10: stationary vector drives the integral into its lower clamp
    for (int i = 0; i < 2000; i++) begin
      sample(0.8, 0.0, 0.0, 0.0, "clamp");
      chk(longint'(freq_o) >= FMIN - 8666000, "R10 freq floor", longint'(freq_o), FMIN - 8666000);
    end

    // R1: reset after activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    model_reset();
    ph = 0.0;
    for (int i = 0; i < 10; i++) sample(0.8, 0.0, 0.0, 60.0, "after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule